// File: doc/BRIEF.md
# SPI Receive FIFO with Overrun Freeze

This block sits between the byte-assembling shifter of an SPI slave and the register port of a processor. Every byte the shifter completes is offered on a valid/ready input. The block stores it in a small circular buffer that has separate read and write pointers and an occupancy counter. The processor sees two register addresses. Reading the data address returns the oldest byte and removes it from the buffer. Reading the status address returns the flags and removes nothing.

The shifter cannot stall, so `wr_ready` does not apply back-pressure. It only reports whether a byte offered in the current cycle will be kept. A byte offered while `wr_ready` is low is lost. If the buffer is full when a byte arrives, a sticky overrun flag is raised. From that point the write side is frozen and every byte is dropped until software writes any value to the status address. While the flag is set, the processor can still drain the bytes that were buffered before it. A receive interrupt request is raised from either flag when the enable input is 1.

Top module: `spi_rx_fifo`

## Requirements
- R1: After reset the status register reads 0, `rx_irq` is 0, `wr_ready` is 1, and a read of the data address returns 0.
- R2: Bytes accepted with `wr_valid` and `wr_ready` high are returned in arrival order by reads of the data address (`cpu_addr`=0 with `cpu_rd`=1). Each such read removes one byte, and the pointers wrap correctly past the last entry.
- R3: Status bit 6 (not-empty) is 1 exactly when at least one unread byte is held. It is set in the cycle after an accepted byte and cleared in the cycle after the read that removes the last byte.
- R4: A byte offered while DEPTH (default 4) bytes are held and the overrun flag is clear is discarded, and status bit 7 (overrun) reads 1 from the next cycle.
- R5: While the overrun flag is set, `wr_ready` is 0 and every offered byte is discarded. Data-address reads still return the buffered bytes in order and remove them.
- R6: The overrun flag stays set until a write strobe (`cpu_wr`=1) to the status address (`cpu_addr`=1) clears it, whatever value is written. That write changes no other status bit and no stored byte. A write to the data address has no effect.
- R7: `rx_irq` equals `rx_ie` AND (overrun OR not-empty).
- R8: A data-address read while the buffer is empty returns the byte most recently removed, or 0 if none has been removed since reset. It moves no pointer, so the next byte accepted is the next one read.
- R9: An offer and a data-address read in the same cycle on a full buffer is an overrun. The read still removes its byte. On a buffer that is not full, both actions take effect.
- R10: Reading the status address removes no byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Shifter offers a completed byte |
| wr_data | input | DW | Offered byte |
| wr_ready | output | 1 | An offer in this cycle will be stored |
| cpu_rd | input | 1 | Processor read strobe |
| cpu_wr | input | 1 | Processor write strobe |
| cpu_addr | input | 1 | 0 = data register, 1 = status register |
| cpu_rdata | output | DW | Read data for `cpu_addr` (combinational) |
| rx_ie | input | 1 | Receive interrupt enable |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
Directed sequences cover these cases: filling and draining across the pointer wrap, a read of an empty buffer, an offer on a full buffer, draining while frozen, clearing through each of the two addresses, and a same-cycle offer and read on a full buffer. Each tells a correct freeze apart from a design that overwrites the oldest entry, keeps accepting bytes, or loses its flag early. A long random phase then mixes offers, reads of both addresses and clear writes at a rate that overruns the buffer often. Every output is compared with a bench model in every cycle, so ordering errors, counter drift and flag timing errors all show up.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  typedef enum logic {
    RXF_ADDR_DATA = 1'b0,
    RXF_ADDR_STAT = 1'b1
  } rxf_addr_e;

  localparam int RXF_OVR_BIT = 7;
  localparam int RXF_NE_BIT  = 6;
  localparam int RXF_STAT_W  = 8;
endpackage

// File: rtl/rxf_ptr.sv
module rxf_ptr #(
  parameter int DEPTH = 4,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [AW-1:0] ptr
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  generate
    if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      // power-of-two depth: natural binary wrap
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   ptr <= '0;
        else if (adv) ptr <= ptr + 1'b1;
      end
    end else begin : g_mod
      // other depths: explicit wrap at the last slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   ptr <= '0;
        else if (adv) ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/rxf_store.sv
module rxf_store #(
  parameter int DW    = 8,
  parameter int DEPTH = 4,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/rxf_flags.sv
module rxf_flags #(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic          pop_req,
  input  logic          clr_req,
  output logic          push_ok,
  output logic          pop_ok,
  output logic [CW-1:0] occ,
  output logic          ovr
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic full;
  logic empty;
  logic ovr_set;

  assign full    = (occ == FULL);
  assign empty   = (occ == '0);
  assign push_ok = push_req && !ovr && !full;
  assign pop_ok  = pop_req && !empty;
  assign ovr_set = push_req && !ovr && full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ <= '0;
    end else begin
      unique case ({push_ok, pop_ok})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovr <= 1'b0;
    else if (ovr_set) ovr <= 1'b1;
    else if (clr_req) ovr <= 1'b0;
  end
endmodule

// File: rtl/spi_rx_fifo.sv
module spi_rx_fifo
  import rxf_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  output logic          wr_ready,
  input  logic          cpu_rd,
  input  logic          cpu_wr,
  input  logic          cpu_addr,
  output logic [DW-1:0] cpu_rdata,
  input  logic          rx_ie,
  output logic          rx_irq
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic          at_data;
  logic          at_stat;
  logic          pop_req;
  logic          clr_req;
  logic          push_ok;
  logic          pop_ok;
  logic [CW-1:0] occ;
  logic          ovr;
  logic          not_empty;
  logic [AW-1:0] wptr;
  logic [AW-1:0] rptr;
  logic [DW-1:0] head;
  logic [DW-1:0] last_q;
  logic [RXF_STAT_W-1:0] stat;

  assign at_data = (cpu_addr == RXF_ADDR_DATA);
  assign at_stat = (cpu_addr == RXF_ADDR_STAT);
  assign pop_req = cpu_rd && at_data;
  assign clr_req = cpu_wr && at_stat;

  rxf_flags #(.DEPTH(DEPTH)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_req (wr_valid),
    .pop_req  (pop_req),
    .clr_req  (clr_req),
    .push_ok  (push_ok),
    .pop_ok   (pop_ok),
    .occ      (occ),
    .ovr      (ovr)
  );

  rxf_ptr #(.DEPTH(DEPTH)) u_wptr (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (push_ok),
    .ptr   (wptr)
  );

  rxf_ptr #(.DEPTH(DEPTH)) u_rptr (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (pop_ok),
    .ptr   (rptr)
  );

  rxf_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .we    (push_ok),
    .waddr (wptr),
    .wdata (wr_data),
    .raddr (rptr),
    .rdata (head)
  );

  // byte most recently removed, returned on an empty read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      last_q <= '0;
    else if (pop_ok) last_q <= head;
  end

  assign not_empty = (occ != '0);
  assign wr_ready  = !ovr && (occ != FULL);
  assign rx_irq    = rx_ie && (ovr || not_empty);

  always_comb begin
    stat              = '0;
    stat[RXF_OVR_BIT] = ovr;
    stat[RXF_NE_BIT]  = not_empty;
  end

  always_comb begin
    cpu_rdata = '0;
    if (at_stat)        cpu_rdata[RXF_STAT_W-1:0] = stat;
    else if (not_empty) cpu_rdata = head;
    else                cpu_rdata = last_q;
  end
endmodule

// File: rtl/rxf_chk.sv
module rxf_chk
  import rxf_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic          cpu_rd,
  input logic          cpu_wr,
  input logic          cpu_addr,
  input logic          rx_ie,
  input logic          rx_irq,
  input logic [CW-1:0] occ,
  input logic          ovr
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  // R4
  full_push_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !ovr && occ == FULL) |=> ovr);

  // R6
  ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !(cpu_wr && cpu_addr == RXF_ADDR_STAT)) |=> ovr);

  // R5
  frozen_occ_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !(cpu_rd && cpu_addr == RXF_ADDR_DATA)) |=> $stable(occ));

  // R5
  ready_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr |-> !wr_ready);

  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> rx_ie);

  // R8
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == '0 && !wr_valid) |=> occ == '0);

  // R10
  stat_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr == RXF_ADDR_STAT && !wr_valid) |=> occ == $past(occ));

  // R3
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= FULL);
endmodule

bind spi_rx_fifo rxf_chk #(.DEPTH(DEPTH)) u_rxf_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_valid (wr_valid),
  .wr_ready (wr_ready),
  .cpu_rd   (cpu_rd),
  .cpu_wr   (cpu_wr),
  .cpu_addr (cpu_addr),
  .rx_ie    (rx_ie),
  .rx_irq   (rx_irq),
  .occ      (occ),
  .ovr      (ovr)
);

// File: tb/test_spi_rx_fifo.sv
`timescale 1ns/1ps
module test_spi_rx_fifo;
  localparam int DW    = 8;
  localparam int DEPTH = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_valid = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          wr_ready;
  logic          cpu_rd = 1'b0;
  logic          cpu_wr = 1'b0;
  logic          cpu_addr = 1'b0;
  logic [DW-1:0] cpu_rdata;
  logic          rx_ie = 1'b0;
  logic          rx_irq;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // bench model state
  logic [DW-1:0] m_mem [DEPTH];
  int            m_rp = 0, m_wp = 0, m_cnt = 0;
  bit            m_ovr = 1'b0;
  logic [DW-1:0] m_last = '0;

  always #10 clk = ~clk;

  spi_rx_fifo #(.DW(DW), .DEPTH(DEPTH)) i_spi_rx_fifo (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ready(wr_ready), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_addr(cpu_addr), .cpu_rdata(cpu_rdata), .rx_ie(rx_ie),
    .rx_irq(rx_irq)
  );

  function automatic logic [DW-1:0] exp_rdata(logic a);
    logic [DW-1:0] r;
    r = '0;
    if (a) begin
      r[7] = m_ovr;
      r[6] = (m_cnt != 0);
    end else if (m_cnt != 0) r = m_mem[m_rp];
    else r = m_last;
    return r;
  endfunction

  function automatic bit exp_ready();
    return !m_ovr && (m_cnt != DEPTH);
  endfunction

  function automatic bit exp_irq(bit ie);
    return ie && (m_ovr || m_cnt != 0);
  endfunction

  task automatic check(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check combinational outputs, clock, update model
  task automatic step(string tag, bit v, logic [DW-1:0] d, bit rd, bit wr, bit a);
    bit full_b, pok, dok;
    wr_valid = v; wr_data = d; cpu_rd = rd; cpu_wr = wr; cpu_addr = a;
    #1;
    check(tag, "rdata", cpu_rdata, exp_rdata(a));
    check(tag, "wr_ready", {7'd0, wr_ready}, {7'd0, exp_ready()});
    check(tag, "rx_irq", {7'd0, rx_irq}, {7'd0, exp_irq(rx_ie)});
    @(posedge clk);
    full_b = (m_cnt == DEPTH);
    pok = v && !m_ovr && !full_b;
    dok = rd && !a && (m_cnt != 0);
    if (dok) begin
      m_last = m_mem[m_rp];
      m_rp = (m_rp + 1) % DEPTH;
    end
    if (pok) begin
      m_mem[m_wp] = d;
      m_wp = (m_wp + 1) % DEPTH;
    end
    m_cnt = m_cnt + (pok ? 1 : 0) - (dok ? 1 : 0);
    if (v && !m_ovr && full_b) m_ovr = 1'b1;
    else if (wr && a) m_ovr = 1'b0;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    rx_ie = 1'b1;
    step("R1", 0, 8'h00, 0, 0, 1);
    step("R1", 0, 8'h00, 1, 0, 0);

    // R2 / R3 / R7: push two, interrupt follows not-empty
    step("R2", 1, 8'hA1, 0, 0, 1);
    step("R3", 1, 8'hB2, 0, 0, 1);
    rx_ie = 1'b0;
    step("R7", 0, 8'h00, 0, 0, 1);
    rx_ie = 1'b1;
    step("R7", 0, 8'h00, 0, 0, 1);
    // R10: status reads do not pop
    step("R10", 0, 8'h00, 1, 0, 1);
    step("R10", 0, 8'h00, 1, 0, 1);
    step("R2", 0, 8'h00, 1, 0, 0);
    step("R2", 0, 8'h00, 1, 0, 0);
    step("R3", 0, 8'h00, 0, 0, 1);
    // R8: empty read keeps last byte and moves nothing
    step("R8", 0, 8'h00, 1, 0, 0);
    step("R8", 1, 8'hC3, 0, 0, 0);
    step("R8", 0, 8'h00, 1, 0, 0);

    // R4 / R5 / R6: fill, overrun, drain while frozen, clear
    for (int i = 0; i < DEPTH; i++) step("R2", 1, 8'h10 + 8'(i), 0, 0, 1);
    step("R4", 1, 8'hEE, 0, 0, 1);
    step("R4", 0, 8'h00, 0, 0, 1);
    step("R5", 1, 8'hEF, 1, 0, 0);
    step("R5", 1, 8'hF0, 0, 0, 1);
    step("R6", 0, 8'h00, 0, 1, 0);
    step("R6", 0, 8'h00, 0, 0, 1);
    for (int i = 0; i < DEPTH; i++) step("R5", 0, 8'h00, 1, 0, 0);
    step("R6", 0, 8'h00, 0, 0, 1);
    step("R6", 0, 8'h00, 0, 1, 1);
    step("R6", 1, 8'h55, 0, 0, 1);
    step("R6", 0, 8'h00, 1, 0, 0);

    // R9: same-cycle offer and read on full, then on non-full
    for (int i = 0; i < DEPTH; i++) step("R9", 1, 8'h20 + 8'(i), 0, 0, 1);
    step("R9", 1, 8'h77, 1, 0, 0);
    step("R9", 0, 8'h00, 0, 1, 1);
    step("R9", 1, 8'h78, 1, 0, 0);
    for (int i = 0; i < DEPTH; i++) step("R9", 0, 8'h00, 1, 0, 0);

    // random mix, all outputs compared every cycle
    for (int i = 0; i < 4000; i++) begin
      bit v, rd, wr, a;
      v  = ($urandom % 100) < 55;
      rd = ($urandom % 100) < 45;
      a  = ($urandom % 100) < 25;
      wr = ($urandom % 100) < 8;
      if (($urandom % 64) == 0) rx_ie = ~rx_ie;
      step("R2", v, 8'($urandom), rd, wr, a);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule